// File: doc/BRIEF.md
# Temperature-Adaptive DRAM Command Timing Gate

This block spaces the commands sent to one DRAM bank. It uses a timing profile that it picks at run time from a temperature reading. A table holds several profiles, and each profile lists four minimum gaps in clock cycles: activate to column access, activate to precharge, write to precharge, and precharge to activate. Profile 0 is for the coolest range and has the shortest gaps. The highest index is the fully margined profile, which must be used from 85 °C upward. The block turns the temperature code into a profile level with hysteresis. It moves to a new level only while the bank has no open row, so a row that is already open finishes with the timing it started with.

A requester holds one command on `req_valid`/`req_cmd` until `grant` pulses. A command that is not yet legal is stalled. Gap down-counters are loaded from the active profile when a command is accepted. Software can rewrite any field of any profile through a single-cycle write port.

Top module: `dram_timing_adapt`

## Requirements
- R1: After reset, `active_set` is the hottest index (NUM_SETS-1, 2 by default), `grant` is low and the bank has no open row.
- R2: While `temp_valid` is low, the hottest set is selected.
- R3: A valid rising temperature selects the highest level k whose threshold HOT_C-(NUM_SETS-1-k)*STEP_C it reaches. By default, 85 °C or more selects set 2, 70 °C or more selects set 1, and anything below selects set 0. A change appears on `active_set` two clock edges after the new code is applied.
- R4: Dropping out of level k needs a temperature strictly below its threshold minus HYST_C. With the defaults, set 2 holds at 82 °C and is left at 81 °C, and set 1 holds at 68 °C and is left at 66 °C.
- R5: The active set changes only while no row is open. A counter that is already running keeps the value it was loaded with.
- R6: A read or write is granted no sooner than tRCD cycles after the activate.
- R7: A precharge is granted no sooner than tRAS cycles after the activate.
- R8: A precharge is granted no sooner than tWR cycles after the last write.
- R9: An activate is granted no sooner than tRP cycles after the precharge. A gap is exactly the profile value when the next request is already waiting, and a value of 0 counts as 1.
- R10: The reset contents are as follows. The hottest set is tRCD 14, tRAS 34, tWR 15, tRP 14. Set 0 is shortened by 17 %, 37 %, 54 % and 35 %, giving 11, 21, 6, 9. Middle sets are interpolated between the two.
- R11: A write with `cfg_we` high stores `cfg_value` into field `cfg_field` of set `cfg_set`. The field codes are 0 = tRCD, 1 = tRAS, 2 = tWR, 3 = tRP. The new value governs the next command that loads that field.
- R12: Commands that do not fit the bank state are never granted. These are read, write or precharge with no open row, and activate with a row open.
- R13: The command codes are 0 = activate, 1 = read, 2 = write, 3 = precharge. `grant` is a registered one-cycle pulse in the cycle after the clock edge that accepts the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_valid | input | 1 | Temperature code is trustworthy |
| temp_code | input | TEMP_W | Temperature in whole °C, unsigned |
| req_valid | input | 1 | Command request present |
| req_cmd | input | 2 | Command code (R13) |
| cfg_we | input | 1 | Profile field write strobe |
| cfg_set | input | SET_W | Profile index to write |
| cfg_field | input | 2 | Field code (R11) |
| cfg_value | input | CNT_W | Gap in cycles |
| grant | output | 1 | Command accepted (one-cycle pulse) |
| active_set | output | SET_W | Index of the profile in use |

## Verification
A grant is due in the cycle after the edge that accepts the command. The bench drives each request on a falling edge and samples `grant` on each following falling edge. It records the edge count at acceptance, so every gap is measured as the exact difference of edge indices and compared with the profile value. A temperature change reaches `active_set` after two rising edges: one registers the hysteresis level, and the next commits it while the bank is closed. The bench therefore samples two edges after driving the code. After a precharge, it samples one edge after the grant. Checks for stalled commands hold the request for more cycles than any gap in the profile and count grants over that window.

// File: rtl/tadapt_pkg.sv
package tadapt_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } dram_cmd_e;

  // Field slots inside one timing profile
  localparam int F_RCD = 0;
  localparam int F_RAS = 1;
  localparam int F_WR  = 2;
  localparam int F_RP  = 3;
  localparam int N_FLD = 4;

  // Reset value of one field for profile idx: the coolest profile is
  // shortened by pct percent, the hottest keeps the margined value.
  function automatic int tadapt_default(int worst, int pct, int idx, int nsets);
    int cool;
    cool = (worst * (100 - pct)) / 100;
    if (nsets < 2) return worst;
    return worst - ((worst - cool) * (nsets - 1 - idx)) / (nsets - 1);
  endfunction

endpackage

// File: rtl/tadapt_timing_store.sv
module tadapt_timing_store
  import tadapt_pkg::*;
#(
  parameter int NUM_SETS = 3,
  parameter int SET_W    = 2,
  parameter int CNT_W    = 6,
  parameter int WC_RCD   = 14,
  parameter int WC_RAS   = 34,
  parameter int WC_WR    = 15,
  parameter int WC_RP    = 14,
  parameter int CUT_RCD  = 17,
  parameter int CUT_RAS  = 37,
  parameter int CUT_WR   = 54,
  parameter int CUT_RP   = 35
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [SET_W-1:0]              wr_set,
  input  logic [1:0]                    wr_fld,
  input  logic [CNT_W-1:0]              wr_val,
  input  logic [SET_W-1:0]              rd_set,
  output logic [N_FLD-1:0][CNT_W-1:0]   rd_t
);

  localparam int WORST [N_FLD] = '{WC_RCD, WC_RAS, WC_WR, WC_RP};
  localparam int CUT   [N_FLD] = '{CUT_RCD, CUT_RAS, CUT_WR, CUT_RP};

  logic set_ok;
  assign set_ok = (int'(wr_set) < NUM_SETS);

  for (genvar f = 0; f < N_FLD; f++) begin : g_fld
    logic [CNT_W-1:0] mem [NUM_SETS];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int s = 0; s < NUM_SETS; s++)
          mem[s] <= CNT_W'(tadapt_default(WORST[f], CUT[f], s, NUM_SETS));
      end else if (wr_en && set_ok && (wr_fld == 2'(f))) begin
        mem[wr_set] <= wr_val;
      end
    end

    assign rd_t[f] = mem[rd_set];
  end

endmodule

// File: rtl/tadapt_level_sel.sv
module tadapt_level_sel #(
  parameter int NUM_SETS = 3,
  parameter int SET_W    = 2,
  parameter int TEMP_W   = 8,
  parameter int HOT_C    = 85,
  parameter int STEP_C   = 15,
  parameter int HYST_C   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              temp_valid,
  input  logic [TEMP_W-1:0] temp_code,
  output logic [SET_W-1:0]  level_q
);

  localparam logic [SET_W-1:0] HOT_LVL = SET_W'(NUM_SETS - 1);

  int               n_up;
  int               n_dn;
  int               thr;
  logic [SET_W-1:0] level_d;

  always_comb begin
    n_up = 0;
    n_dn = 0;
    thr  = 0;
    for (int k = 1; k < NUM_SETS; k++) begin
      thr = HOT_C - (NUM_SETS - 1 - k) * STEP_C;
      if (int'(temp_code) >= thr)          n_up = n_up + 1;
      if (int'(temp_code) >= thr - HYST_C) n_dn = n_dn + 1;
    end
    if (!temp_valid)                  level_d = HOT_LVL;
    else if (n_up > int'(level_q))    level_d = SET_W'(n_up);
    else if (n_dn < int'(level_q))    level_d = SET_W'(n_dn);
    else                              level_d = level_q;
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= HOT_LVL;
    else     level_q <= level_d;
  end

endmodule

// File: rtl/tadapt_gap_cnt.sv
module tadapt_gap_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] gap,
  output logic             clear
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= (gap == '0) ? '0 : gap - 1'b1;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign clear = (cnt_q == '0);

endmodule

// File: rtl/tadapt_cmd_gate.sv
module tadapt_cmd_gate
  import tadapt_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [1:0]                  req_cmd,
  input  logic [N_FLD-1:0][CNT_W-1:0] cur_t,
  output logic                        grant,
  output logic                        row_open,
  output logic                        act_take
);

  dram_cmd_e        cmd;
  logic             allowed;
  logic             take;
  logic [N_FLD-1:0] load;
  logic [N_FLD-1:0] clear;

  assign cmd = dram_cmd_e'(req_cmd);

  always_comb begin
    case (cmd)
      CMD_ACT: allowed = !row_open && clear[F_RP];
      CMD_RD,
      CMD_WR:  allowed = row_open && clear[F_RCD];
      default: allowed = row_open && clear[F_RAS] && clear[F_WR];
    endcase
  end

  assign take     = req_valid && allowed;
  assign act_take = take && (cmd == CMD_ACT);

  assign load[F_RCD] = act_take;
  assign load[F_RAS] = act_take;
  assign load[F_WR]  = take && (cmd == CMD_WR);
  assign load[F_RP]  = take && (cmd == CMD_PRE);

  for (genvar f = 0; f < N_FLD; f++) begin : g_cnt
    tadapt_gap_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .load  (load[f]),
      .gap   (cur_t[f]),
      .clear (clear[f])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant    <= 1'b0;
      row_open <= 1'b0;
    end else begin
      grant <= take;
      if (act_take)                         row_open <= 1'b1;
      else if (take && (cmd == CMD_PRE))    row_open <= 1'b0;
    end
  end

endmodule

// File: rtl/dram_timing_adapt.sv
module dram_timing_adapt
  import tadapt_pkg::*;
#(
  parameter int NUM_SETS = 3,
  parameter int TEMP_W   = 8,
  parameter int CNT_W    = 6,
  parameter int HOT_C    = 85,
  parameter int STEP_C   = 15,
  parameter int HYST_C   = 3,
  parameter int WC_RCD   = 14,
  parameter int WC_RAS   = 34,
  parameter int WC_WR    = 15,
  parameter int WC_RP    = 14,
  parameter int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              temp_valid,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic              cfg_we,
  input  logic [SET_W-1:0]  cfg_set,
  input  logic [1:0]        cfg_field,
  input  logic [CNT_W-1:0]  cfg_value,
  output logic              grant,
  output logic [SET_W-1:0]  active_set
);

  localparam logic [SET_W-1:0] HOT_LVL = SET_W'(NUM_SETS - 1);

  logic [SET_W-1:0]              level_q;
  logic [SET_W-1:0]              sel_q;
  logic [N_FLD-1:0][CNT_W-1:0]   cur_t;
  logic                          row_open;
  logic                          act_take;

  tadapt_level_sel #(
    .NUM_SETS (NUM_SETS), .SET_W (SET_W), .TEMP_W (TEMP_W),
    .HOT_C    (HOT_C),    .STEP_C(STEP_C), .HYST_C (HYST_C)
  ) u_level (
    .clk        (clk),
    .rst        (rst),
    .temp_valid (temp_valid),
    .temp_code  (temp_code),
    .level_q    (level_q)
  );

  // Commit the requested level only with no row open and no activate
  // being accepted on this edge, so a row never mixes two profiles.
  always_ff @(posedge clk) begin
    if (rst)                                          sel_q <= HOT_LVL;
    else if (!row_open && !act_take && level_q != sel_q) sel_q <= level_q;
  end

  assign active_set = sel_q;

  tadapt_timing_store #(
    .NUM_SETS (NUM_SETS), .SET_W (SET_W), .CNT_W (CNT_W),
    .WC_RCD   (WC_RCD),   .WC_RAS(WC_RAS), .WC_WR (WC_WR), .WC_RP (WC_RP)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_we),
    .wr_set (cfg_set),
    .wr_fld (cfg_field),
    .wr_val (cfg_value),
    .rd_set (sel_q),
    .rd_t   (cur_t)
  );

  tadapt_cmd_gate #(.CNT_W(CNT_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_cmd   (req_cmd),
    .cur_t     (cur_t),
    .grant     (grant),
    .row_open  (row_open),
    .act_take  (act_take)
  );

endmodule

// File: rtl/tadapt_chk.sv
module tadapt_chk #(
  parameter int NUM_SETS = 3,
  parameter int SET_W    = 2,
  parameter int CNT_W    = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             temp_valid,
  input logic             req_valid,
  input logic [1:0]       req_cmd,
  input logic             grant,
  input logic [SET_W-1:0] active_set,
  input logic             row_open,
  input logic [CNT_W-1:0] t_rcd,
  input logic [CNT_W-1:0] t_ras,
  input logic [CNT_W-1:0] t_wr,
  input logic [CNT_W-1:0] t_rp
);

  localparam int               GW   = CNT_W + 2;
  localparam logic [GW-1:0]    GMAX = '1;
  localparam logic [SET_W-1:0] HOT  = SET_W'(NUM_SETS - 1);

  function automatic logic [GW-1:0] eff(input logic [CNT_W-1:0] t);
    return (t == '0) ? GW'(1) : GW'(t);
  endfunction

  logic [1:0]       cmd_q;
  logic [CNT_W-1:0] p_rcd, p_ras, p_wr, p_rp;
  logic [CNT_W-1:0] l_rcd, l_ras, l_wr, l_rp;
  logic [GW-1:0]    since_act, since_wr, since_pre;
  logic             g_act, g_rd, g_wr, g_pre;

  assign g_act = grant && (cmd_q == 2'd0);
  assign g_rd  = grant && (cmd_q == 2'd1);
  assign g_wr  = grant && (cmd_q == 2'd2);
  assign g_pre = grant && (cmd_q == 2'd3);

  always_ff @(posedge clk) begin
    cmd_q <= req_cmd;
    p_rcd <= t_rcd;
    p_ras <= t_ras;
    p_wr  <= t_wr;
    p_rp  <= t_rp;
    if (rst) begin
      since_act <= GMAX;
      since_wr  <= GMAX;
      since_pre <= GMAX;
      l_rcd <= '0; l_ras <= '0; l_wr <= '0; l_rp <= '0;
    end else begin
      if (g_act) begin
        since_act <= GW'(1); l_rcd <= p_rcd; l_ras <= p_ras;
      end else if (since_act != GMAX) since_act <= since_act + 1'b1;
      if (g_wr) begin
        since_wr <= GW'(1); l_wr <= p_wr;
      end else if (since_wr != GMAX) since_wr <= since_wr + 1'b1;
      if (g_pre) begin
        since_pre <= GW'(1); l_rp <= p_rp;
      end else if (since_pre != GMAX) since_pre <= since_pre + 1'b1;
    end
  end

  // R6
  rcd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (g_rd || g_wr) |-> since_act >= eff(l_rcd));

  // R7
  ras_gap_chk: assert property (@(posedge clk) disable iff (rst)
    g_pre |-> since_act >= eff(l_ras));

  // R8
  wr_gap_chk: assert property (@(posedge clk) disable iff (rst)
    g_pre |-> since_wr >= eff(l_wr));

  // R9
  rp_gap_chk: assert property (@(posedge clk) disable iff (rst)
    g_act |-> since_pre >= eff(l_rp));

  // R12
  closed_col_chk: assert property (@(posedge clk) disable iff (rst)
    (g_rd || g_wr || g_pre) |-> $past(row_open));

  // R12
  open_act_chk: assert property (@(posedge clk) disable iff (rst)
    g_act |-> !$past(row_open));

  // R13
  grant_req_chk: assert property (@(posedge clk) disable iff (rst)
    grant |-> $past(req_valid));

  // R5
  hold_open_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(row_open) && !$past(rst)) |-> $stable(active_set));

  // R2
  invalid_hot_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(temp_valid, 2) && !$past(row_open) && !g_act) |-> active_set == HOT);

endmodule

bind dram_timing_adapt tadapt_chk #(
  .NUM_SETS (NUM_SETS), .SET_W (SET_W), .CNT_W (CNT_W)
) u_tadapt_chk (
  .clk        (clk),
  .rst        (rst),
  .temp_valid (temp_valid),
  .req_valid  (req_valid),
  .req_cmd    (req_cmd),
  .grant      (grant),
  .active_set (active_set),
  .row_open   (row_open),
  .t_rcd      (cur_t[0]),
  .t_ras      (cur_t[1]),
  .t_wr       (cur_t[2]),
  .t_rp       (cur_t[3])
);

// File: tb/tb_dram_timing_adapt.sv
`timescale 1ns/1ps
module tb_dram_timing_adapt;

  localparam int SET_W = 2;
  localparam int CNT_W = 6;

  logic             clk = 1'b0;
  logic             rst;
  logic             temp_valid;
  logic [7:0]       temp_code;
  logic             req_valid;
  logic [1:0]       req_cmd;
  logic             cfg_we;
  logic [SET_W-1:0] cfg_set;
  logic [1:0]       cfg_field;
  logic [CNT_W-1:0] cfg_value;
  logic             grant;
  logic [SET_W-1:0] active_set;

  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_timing_adapt dut (
    .clk(clk), .rst(rst), .temp_valid(temp_valid), .temp_code(temp_code),
    .req_valid(req_valid), .req_cmd(req_cmd), .cfg_we(cfg_we),
    .cfg_set(cfg_set), .cfg_field(cfg_field), .cfg_value(cfg_value),
    .grant(grant), .active_set(active_set)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Present a command and wait for its grant; returns the accepting edge.
  task automatic issue(input logic [1:0] c, output int edge_no);
    req_cmd   = c;
    req_valid = 1'b1;
    edge_no   = -1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (grant) begin
        edge_no = cyc;
        break;
      end
    end
    req_valid = 1'b0;
    if (edge_no < 0) check("R13 grant timeout", 0, 1);
  endtask

  task automatic set_temp(input logic v, input int t, input int exp, input string tag);
    temp_valid = v;
    temp_code  = 8'(t);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(tag, int'(active_set), exp);
  endtask

  task automatic cfg_write(input int s, input int f, input int val);
    cfg_set = SET_W'(s); cfg_field = 2'(f); cfg_value = CNT_W'(val); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic hold_no_grant(input logic [1:0] c, input int n, input string tag);
    int seen = 0;
    req_cmd = c; req_valid = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (grant) seen++;
    end
    req_valid = 1'b0;
    @(negedge clk);
    if (grant) seen++;
    check(tag, seen, 0);
  endtask

  task automatic t_reset();
    check("R1 active_set after reset", int'(active_set), 2);
    check("R1 grant low after reset", int'(grant), 0);
  endtask

  task automatic t_worst_defaults();
    int a, r, p, a2, w, p2;
    issue(2'd0, a);
    issue(2'd1, r);  check("R6 R10 ACT-RD worst", r - a, 14);
    issue(2'd3, p);  check("R7 R10 ACT-PRE worst", p - a, 34);
    issue(2'd0, a2); check("R9 R10 PRE-ACT worst", a2 - p, 14);
    issue(2'd2, w);  check("R6 ACT-WR worst", w - a2, 14);
    issue(2'd3, p2); check("R7 ACT-PRE after write", p2 - a2, 34);
  endtask

  task automatic t_select();
    set_temp(1'b1, 25, 0, "R3 25C set0");
    set_temp(1'b1, 75, 1, "R3 75C set1");
    set_temp(1'b1, 85, 2, "R3 85C set2");
    set_temp(1'b1, 84, 2, "R4 84C holds set2");
    set_temp(1'b1, 82, 2, "R4 82C holds set2");
    set_temp(1'b1, 81, 1, "R4 81C drops to set1");
    set_temp(1'b1, 68, 1, "R4 68C holds set1");
    set_temp(1'b1, 66, 0, "R4 66C drops to set0");
    set_temp(1'b0, 25, 2, "R2 invalid gives set2");
    set_temp(1'b1, 25, 0, "R3 25C back to set0");
  endtask

  task automatic t_cool_defaults();
    int a, r, p, a2;
    issue(2'd0, a);
    issue(2'd1, r);  check("R10 ACT-RD cool", r - a, 11);
    issue(2'd3, p);  check("R10 ACT-PRE cool", p - a, 21);
    issue(2'd0, a2); check("R10 PRE-ACT cool", a2 - p, 9);
    issue(2'd3, p);
  endtask

  task automatic t_config();
    int a, w, p;
    cfg_write(0, 0, 2);
    cfg_write(0, 1, 2);
    cfg_write(0, 2, 9);
    cfg_write(3, 2, 1);   // index beyond the table: no effect
    issue(2'd0, a);
    issue(2'd2, w);  check("R11 written tRCD", w - a, 2);
    issue(2'd3, p);  check("R8 R11 WR-PRE written tWR", p - w, 9);
  endtask

  task automatic t_switch();
    int a, p, a2;
    issue(2'd0, a);
    temp_valid = 1'b1; temp_code = 8'd90;
    repeat (4) @(negedge clk);
    check("R5 no switch with row open", int'(active_set), 0);
    issue(2'd3, p);
    @(negedge clk);
    check("R5 switch after close", int'(active_set), 2);
    issue(2'd0, a2); check("R5 in-flight tRP kept", a2 - p, 9);
  endtask

  task automatic t_illegal();
    int p;
    hold_no_grant(2'd0, 40, "R12 ACT while open");
    issue(2'd3, p);
    @(negedge clk);
    check("R13 grant single pulse", int'(grant), 0);
    hold_no_grant(2'd1, 20, "R12 RD while closed");
    hold_no_grant(2'd2, 10, "R12 WR while closed");
    hold_no_grant(2'd3, 10, "R12 PRE while closed");
  endtask

  initial begin
    rst = 1'b1; temp_valid = 1'b0; temp_code = '0; req_valid = 1'b0;
    req_cmd = '0; cfg_we = 1'b0; cfg_set = '0; cfg_field = '0; cfg_value = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_worst_defaults();
    t_select();
    t_cool_defaults();
    t_config();
    t_switch();
    t_illegal();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule